// File: doc/BRIEF.md
# Window Watchdog Timer

This block guards a processor against runaway code. A counter advances on each pulse of a slow low-speed clock enable. Software must restart it before it reaches the selected overflow length. The restart is a byte write of the key 0xAC to the key register. Outside the first restart after reset release, that write is accepted only in the open window, which is the late part of each period. A restart that comes too early, a wrong key, a single-bit access to the key register, or a counter overflow raises an internal reset request. That request stays high until the chip reset controller pulls `rst_n` low.

An eight-bit configuration byte is captured on the first clock after reset release. It fixes five things:
- whether the watchdog runs;
- the overflow length;
- the open-window size;
- whether a one-cycle interrupt marks three quarters of the period;
- whether counting continues during standby.

A sticky cause flag in the power-on domain records that the watchdog caused a reset. Software can read it after the restart.

Top module: `window_watchdog`

## Requirements
- R1: The configuration byte is sampled on the first clock edge after `rst_n` is released. Its bit layout is: [7] interrupt enable, [6:5] window code, [4] watchdog enable, [3:1] overflow code, [0] run during standby. Later changes on `cfg_byte` have no effect until the next reset.
- R2: When bit 4 of the latched byte is 0, `rst_req` and `irq_75` never go high, whatever the ticks, writes or bit accesses.
- R3: With no restart, `rst_req` rises on the clock edge that takes the L-th tick after start, where L is the overflow length. Once high, it stays high until `rst_n` goes low.
- R4: A restart sets the count to zero, so a new full period of L ticks is needed before an overflow.
- R5: A byte write of any value other than 0xAC raises `rst_req` one clock later. This holds even for the first write after reset.
- R6: Any single-bit access to the key register (`key_bitop` high) raises `rst_req`.
- R7: After the first restart, a write of 0xAC while the count is below the closed limit raises `rst_req`. Window code 2'b01 closes the first half of the period, code 2'b10 closes the first quarter, and codes 2'b11 and 2'b00 close nothing.
- R8: The first 0xAC write after reset release is accepted at any count below overflow, whatever the window code.
- R9: When bit 7 is set, `irq_75` pulses for exactly one clock on the edge that takes the tick at which the count reaches 3L/4. When bit 7 is clear it never pulses.
- R10: When bit 0 is 0, counting is frozen while `standby` is high, and the count restarts from zero when `standby` falls. In this mode no write is ever early.
- R11: When bit 0 is 1, counting continues while `standby` is high.
- R12: `wdt_flag` goes high one clock after `rst_req`. It survives a pulse on `rst_n` and is cleared by a `flag_rd` pulse or by `por_n`.
- R13: Overflow codes 0 to 7 give L = 64, 128, 256, 512, 2048, 8192, 16384 and 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause flag |
| rst_n | input | 1 | Chip reset, active low |
| lsclk_en | input | 1 | One-clock pulse per low-speed clock period |
| cfg_byte | input | 8 | Configuration byte, sampled after reset release |
| key_wr | input | 1 | Byte write strobe for the key register |
| key_bitop | input | 1 | Single-bit access strobe for the key register |
| key_data | input | 8 | Write data for the key register |
| standby | input | 1 | Processor is in a standby mode |
| flag_rd | input | 1 | Read of the cause flag; clears it |
| rst_req | output | 1 | Pending internal reset request |
| irq_75 | output | 1 | Three-quarter interval interrupt pulse |
| wdt_flag | output | 1 | Sticky watchdog reset cause |

## Verification
The count itself is hidden, so the hardest case to reach is a write that lands exactly on either side of the closed limit.

The stimulus reaches that edge by counting low-speed ticks precisely after a known restart. It places a key write at the last closed count and at the first open count, and each of these starts from a fresh reset. The standby freeze is shown the same way. A long run of ticks during standby must not overflow. After `standby` falls, an early-position write must be accepted, and exactly L further ticks must then trip the request.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

  localparam logic [7:0] RESTART_KEY = 8'hAC;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] win;
    logic       enable;
    logic [2:0] ovf_sel;
    logic       stby_run;
  } wwdg_cfg_t;

  // log2 of the overflow length for each selection code
  function automatic int unsigned ovf_exp(input logic [2:0] sel);
    case (sel)
      3'd0:    return 6;
      3'd1:    return 7;
      3'd2:    return 8;
      3'd3:    return 9;
      3'd4:    return 11;
      3'd5:    return 13;
      3'd6:    return 14;
      default: return 16;
    endcase
  endfunction

  // count below which a restart is early; 0 means always open
  function automatic int unsigned close_len(input int unsigned len,
                                            input logic [1:0]  win,
                                            input logic        stby_run);
    if (!stby_run) return 0;
    case (win)
      2'b01:   return len / 2;
      2'b10:   return len / 4;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned irq_mark(input int unsigned len);
    return len - len / 4;
  endfunction

endpackage

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             freeze,
  input  logic             clear,
  input  logic             irq_en,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] irq_at,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             irq_pulse
);

  logic             step;
  logic [LEN_W-1:0] nxt;

  assign step    = run && tick && !freeze;
  assign nxt     = {1'b0, cnt} + LEN_W'(1);
  assign ovf_evt = step && !clear && (nxt == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= irq_en && step && !clear && (nxt == irq_at);
      if (clear || !run) cnt <= '0;
      else if (step)     cnt <= nxt[CNT_W-1:0];
    end
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt} < len));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && freeze && !clear) |=> (cnt == $past(cnt) || !run));

endmodule

// File: rtl/wwdg_access.sv
module wwdg_access
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             key_wr,
  input  logic             key_bitop,
  input  logic [7:0]       key_data,
  input  logic [CNT_W-1:0] cnt,
  input  logic [LEN_W-1:0] close_lim,
  output logic             restart,
  output logic             violation
);

  logic first_done;
  logic key_ok;
  logic early;

  assign key_ok    = (key_data == RESTART_KEY);
  assign early     = first_done && ({1'b0, cnt} < close_lim);
  assign violation = active && (key_bitop || (key_wr && (!key_ok || early)));
  assign restart   = active && key_wr && !key_bitop && key_ok && !early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       first_done <= 1'b0;
    else if (restart) first_done <= 1'b1;
  end

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && key_wr) |-> (restart != violation));

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       lsclk_en,
  input  logic [7:0] cfg_byte,
  input  logic       key_wr,
  input  logic       key_bitop,
  input  logic [7:0] key_data,
  input  logic       standby,
  input  logic       flag_rd,
  output logic       rst_req,
  output logic       irq_75,
  output logic       wdt_flag
);

  localparam int LEN_W = CNT_W + 1;

  wwdg_cfg_t        cfg_q;
  logic             started;
  logic             stby_d;
  logic             run;
  logic             stby_exit;
  logic             restart;
  logic             violation;
  logic             ovf_evt;
  logic [CNT_W-1:0] cnt;
  int unsigned      len_i;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] close_lim;
  logic [LEN_W-1:0] irq_at;

  always_comb len_i = 32'd1 << ovf_exp(cfg_q.ovf_sel);
  assign len       = LEN_W'(len_i);
  assign close_lim = LEN_W'(close_len(len_i, cfg_q.win, cfg_q.stby_run));
  assign irq_at    = LEN_W'(irq_mark(len_i));

  assign run       = started && cfg_q.enable && !rst_req;
  assign stby_exit = stby_d && !standby && !cfg_q.stby_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      started <= 1'b0;
      stby_d  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (!started) begin
        cfg_q   <= wwdg_cfg_t'(cfg_byte);
        started <= 1'b1;
      end
      stby_d <= standby;
      if (violation || ovf_evt) rst_req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       wdt_flag <= 1'b0;
    else if (rst_req) wdt_flag <= 1'b1;
    else if (flag_rd) wdt_flag <= 1'b0;
  end

  wwdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(lsclk_en),
    .freeze(standby && !cfg_q.stby_run), .clear(restart || stby_exit),
    .irq_en(cfg_q.irq_en), .len(len), .irq_at(irq_at),
    .cnt(cnt), .ovf_evt(ovf_evt), .irq_pulse(irq_75)
  );

  wwdg_access #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .active(run), .key_wr(key_wr),
    .key_bitop(key_bitop), .key_data(key_data), .cnt(cnt),
    .close_lim(close_lim), .restart(restart), .violation(violation)
  );

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !cfg_q.enable) |-> (!rst_req && !irq_75));

  assert_badkey_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && key_wr && key_data != RESTART_KEY) |=> rst_req);

  assert_bitop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && key_bitop) |=> rst_req);

  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  assert_flag_set_R12: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> wdt_flag);

endmodule

// File: tb/window_watchdog_tb_top.sv
module window_watchdog_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, lsclk_en = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic key_wr = 1'b0, key_bitop = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic standby = 1'b0, flag_rd = 1'b0;
  logic rst_req, irq_75, wdt_flag;

  int checks = 0, fails = 0, tick_no = 0;
  int exp_irq_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window_watchdog dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .lsclk_en(lsclk_en),
    .cfg_byte(cfg_byte), .key_wr(key_wr), .key_bitop(key_bitop),
    .key_data(key_data), .standby(standby), .flag_rd(flag_rd),
    .rst_req(rst_req), .irq_75(irq_75), .wdt_flag(wdt_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected interrupt tick numbers (R9)
  always @(negedge clk) begin
    if (rst_n && irq_75) begin
      checks++;
      if (exp_irq_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected irq actual=tick %0d expected=none", tick_no);
      end else begin
        int e;
        e = exp_irq_q.pop_front();
        if (e != tick_no) begin
          fails++;
          $display("FAIL R9 irq tick actual=%0d expected=%0d", tick_no, e);
        end
      end
    end
  end

  task automatic do_reset(input logic [7:0] c);
    @(negedge clk);
    rst_n = 1'b0; lsclk_en = 1'b0; key_wr = 1'b0; key_bitop = 1'b0;
    standby = 1'b0; flag_rd = 1'b0; cfg_byte = c; tick_no = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lsclk_en = 1'b1; tick_no++;
      @(negedge clk); lsclk_en = 1'b0;
    end
  endtask

  task automatic wr_key(input logic [7:0] d);
    @(negedge clk); key_wr = 1'b1; key_data = d;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    do_reset(8'hF1);
    check("reset rst_req", rst_req, 0);
    check("reset irq_75", irq_75, 0);
    check("reset wdt_flag", wdt_flag, 0);

    // R3 R9 R13: code 0 -> 64 ticks, irq at tick 48
    exp_irq_q.push_back(48);
    tick(63);
    check("R3 no overflow at 63", rst_req, 0);
    tick(1);
    check("R3 overflow at 64", rst_req, 1);
    check("R9 irq consumed", exp_irq_q.size(), 0);
    tick(5);
    check("R3 request held", rst_req, 1);
    check("R12 flag set", wdt_flag, 1);
    do_reset(8'h11);
    check("R12 flag survives rst_n", wdt_flag, 1);
    check("R3 request cleared by rst_n", rst_req, 0);
    @(negedge clk); flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
    check("R12 flag cleared by read", wdt_flag, 0);

    // R13: code 1 -> 128, code 4 -> 2048
    do_reset(8'h73);
    tick(127); check("R13 code1 at 127", rst_req, 0);
    tick(1);   check("R13 code1 at 128", rst_req, 1);
    do_reset(8'h79);
    tick(2047); check("R13 code4 at 2047", rst_req, 0);
    tick(1);    check("R13 code4 at 2048", rst_req, 1);

    // R8 R7: 50% window (code 01)
    do_reset(8'h31);
    tick(5); wr_key(8'hAC);
    check("R8 first restart early accepted", rst_req, 0);
    tick(31); wr_key(8'hAC);
    check("R7 write at count 31 of 50pct is early", rst_req, 1);
    do_reset(8'h31);
    tick(5); wr_key(8'hAC); tick(32); wr_key(8'hAC);
    check("R7 write at count 32 of 50pct accepted", rst_req, 0);
    tick(63); check("R4 full period after restart", rst_req, 0);
    tick(1);  check("R4 overflow after restart", rst_req, 1);

    // R7: 75% window (code 10) closes below 16
    do_reset(8'h51);
    wr_key(8'hAC); tick(15); wr_key(8'hAC);
    check("R7 75pct write at 15 early", rst_req, 1);
    do_reset(8'h51);
    wr_key(8'hAC); tick(16); wr_key(8'hAC);
    check("R7 75pct write at 16 accepted", rst_req, 0);
    // R7: code 00 treated as fully open
    do_reset(8'h11);
    wr_key(8'hAC); tick(1); wr_key(8'hAC);
    check("R7 code 00 fully open", rst_req, 0);

    // R5 wrong key, R6 bit access
    do_reset(8'h71);
    wr_key(8'hAB);
    check("R5 wrong first key", rst_req, 1);
    do_reset(8'h71);
    wr_key(8'hAC); tick(10); wr_key(8'h00);
    check("R5 wrong key later", rst_req, 1);
    do_reset(8'h71);
    tick(3);
    @(negedge clk); key_bitop = 1'b1; @(negedge clk); key_bitop = 1'b0;
    check("R6 bit access", rst_req, 1);

    // R12: por clears flag
    check("R12 flag before por", wdt_flag, 1);
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    check("R12 flag cleared by por", wdt_flag, 0);

    // R2 disabled: nothing happens
    do_reset(8'hE1);
    tick(100); wr_key(8'h00);
    @(negedge clk); key_bitop = 1'b1; @(negedge clk); key_bitop = 1'b0;
    check("R2 disabled no request", rst_req, 0);

    // R1 config change after release ignored
    do_reset(8'h11);
    cfg_byte = 8'h00;
    tick(64);
    check("R1 config held after release", rst_req, 1);

    // R10 standby freeze, window forced open
    do_reset(8'h30);
    wr_key(8'hAC); tick(10);
    @(negedge clk); standby = 1'b1;
    tick(100);
    check("R10 frozen in standby", rst_req, 0);
    @(negedge clk); standby = 1'b0;
    tick(5); wr_key(8'hAC);
    check("R10 window open without standby run", rst_req, 0);
    tick(63); check("R10 count from zero", rst_req, 0);
    tick(1);  check("R10 overflow after restart", rst_req, 1);

    // R11 counting continues in standby
    do_reset(8'h71);
    tick(30);
    @(negedge clk); standby = 1'b1;
    tick(34);
    check("R11 runs in standby", rst_req, 1);
    @(negedge clk); standby = 1'b0;

    check("R9 queue empty", exp_irq_q.size(), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule